// File: doc/BRIEF.md
# Pseudo-static RAM refresh scheduler

This block sits on the host side of a pseudo-static RAM and keeps its dynamic cells refreshed. In normal operation it issues distributed automatic refresh pulses on the shared active-low refresh strobe while chip enable is high. Each pulse is timed to stay well inside the window that the memory reads as an automatic refresh and not as the start of self refresh. An interval counter raises a pending flag when a refresh is due. If the refresh has still not started when a hard deadline passes, the block reports it on a sticky error output.

The block shares the memory pins with an access sequencer through a request/grant handshake. The scheduler raises `req_o` only while `seq_busy_i` is low. Once raised, `req_o` stays high through the whole refresh pulse and its recovery time, and through the whole self-refresh episode. The sequencer answers with `gnt_i` and must hold it for as long as `req_o` stays high, keeping chip enable high and starting no access. The scheduler waits, with no time limit, for a grant that is withheld. This is its only back-pressure point.

A level-sensitive sleep input puts the memory into self refresh by holding the strobe low. After the strobe has been low for the minimum self-refresh time plus margin, dropping sleep makes the block release the strobe. It then keeps the bus for a reset gap and fires a catch-up refresh before it hands the bus back. All durations are given in nanoseconds and converted to cycles from the clock-period parameter `CLK_NS`. The cycle figures below apply at the defaults (10 ns clock).

Top module: `psr_refresh_sched`

## Requirements
- R1: After reset, `rfsh_n_o` is 1 and `req_o`, `pend_o`, `err_o` and `self_o` are 0.
- R2: `pend_o` rises exactly INT_CYC (1500) cycles after reset or after the start of the previous refresh pulse, and clears in the cycle the next pulse starts. With the bus free, consecutive pulses start between INT_CYC and DEAD_CYC (1560) cycles apart.
- R3: `req_o` rises only in a cycle following one with `seq_busy_i` low, and while `seq_busy_i` is high no request is made even when a refresh is pending. `req_o` is high whenever `rfsh_n_o` is low.
- R4: The strobe never falls before `gnt_i` is high. A withheld grant delays the refresh indefinitely.
- R5: The strobe falls only after `ce_n_i` has been high for at least CE_CYC (5) consecutive cycles (50 ns).
- R6: An automatic refresh pulse holds `rfsh_n_o` low for exactly PULSE_CYC (10) cycles. `req_o` then stays high for exactly RECOV_CYC (10) further cycles with the strobe high.
- R7: `err_o` becomes 1 exactly DEAD_CYC cycles after the last refresh start (or reset) when no refresh has started meanwhile, and it stays 1 until reset.
- R8: While `sleep_i` is acted on, `rfsh_n_o` is held low continuously and `self_o` is 1. The interval counter is frozen at zero, so `pend_o` and `err_o` stay 0 however long the sleep lasts.
- R9: In self refresh the strobe stays low for at least SELF_CYC (900) cycles (9 µs) even if `sleep_i` drops earlier. A short sleep gives a low time of SELF_CYC or SELF_CYC+1 cycles.
- R10: On exit from self refresh, `rfsh_n_o` stays high for at least GAP_CYC (70) cycles (700 ns) while `req_o` stays high. A catch-up refresh pulse follows before `req_o` is released, well within INT_CYC cycles of the exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_busy_i | input | 1 | Access sequencer has an access in progress |
| ce_n_i | input | 1 | Memory chip enable as driven by the sequencer (active low) |
| gnt_i | input | 1 | Sequencer yields the memory; held while `req_o` is high |
| sleep_i | input | 1 | Level request for self refresh |
| req_o | output | 1 | Scheduler needs the memory pins |
| rfsh_n_o | output | 1 | Refresh strobe contribution, active low, idle high |
| pend_o | output | 1 | A refresh is due |
| self_o | output | 1 | Memory is in self refresh |
| err_o | output | 1 | Sticky: refresh deadline missed |

## Verification
On every cycle the assertions check the pin-level safety rules: a strobe low only under a held request, a fall only after a grant and a long enough chip-enable-high run, pulses no shorter than the refresh minimum, high time between pulses, the self-refresh minimum low time, and an error only after a pending refresh. The exact cycle counts cannot be seen by these local rules, and only the bench scenarios show them. These are the 1500-cycle due point, the 1560-cycle error point, the recovery length, the reset gap with the held request, and the catch-up pulse. The scenarios also show that a busy sequencer or a withheld grant really holds off a refresh and that a long sleep never raises the pending or error flags.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_CEW,
    ST_PULSE,
    ST_RECOV,
    ST_SREQ,
    ST_SCEW,
    ST_SELF,
    ST_GAP
  } psr_state_e;

  // Round a duration in ns up to whole clock cycles.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psr_interval.sv
// Counts cycles since the last refresh start; flags due and overdue.
module psr_interval #(
  parameter int INT_CYC  = 1500,
  parameter int DEAD_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic pend_o,
  output logic err_o
);
  localparam int W = $clog2(DEAD_CYC + 1);

  logic [W-1:0] icnt;
  logic         err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt  <= '0;
      err_q <= 1'b0;
    end else begin
      if (clr_i)
        icnt <= '0;
      else if (icnt != W'(DEAD_CYC))
        icnt <= icnt + 1'b1;
      if (!clr_i && (icnt == W'(DEAD_CYC - 1)))
        err_q <= 1'b1;
    end
  end

  assign pend_o = (icnt >= W'(INT_CYC));
  assign err_o  = err_q;
endmodule

// File: rtl/psr_ce_watch.sv
// Measures how long chip enable has been high, saturating at the limit.
module psr_ce_watch #(
  parameter int CE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  output logic ce_ok_o
);
  localparam int W = $clog2(CE_CYC + 1);

  logic [W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else if (!ce_n_i)
      run <= '0;
    else if (run != W'(CE_CYC))
      run <= run + 1'b1;
  end

  assign ce_ok_o = (run == W'(CE_CYC));
endmodule

// File: rtl/psr_seq_fsm.sv
// Sequences request, chip-enable wait, pulse, recovery and self refresh.
module psr_seq_fsm
  import psr_pkg::*;
#(
  parameter int PULSE_CYC = 10,
  parameter int RECOV_CYC = 10,
  parameter int SELF_CYC  = 900,
  parameter int GAP_CYC   = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic busy_i,
  input  logic gnt_i,
  input  logic sleep_i,
  input  logic ce_ok_i,
  output logic req_o,
  output logic rfsh_n_o,
  output logic self_o,
  output logic issue_o,
  output logic hold_o
);
  localparam int TMAX = max2(max2(PULSE_CYC, RECOV_CYC), max2(SELF_CYC, GAP_CYC));
  localparam int TW   = $clog2(TMAX + 1);

  psr_state_e st, nxt;
  logic [TW-1:0] tmr;
  logic req_q, strobe_q, self_q;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (!busy_i && pend_i)       nxt = ST_REQ;
                else if (!busy_i && sleep_i) nxt = ST_SREQ;
      ST_REQ:   if (gnt_i)   nxt = ST_CEW;
      ST_CEW:   if (ce_ok_i) nxt = ST_PULSE;
      ST_PULSE: if (tmr == TW'(PULSE_CYC - 1)) nxt = ST_RECOV;
      ST_RECOV: if (tmr == TW'(RECOV_CYC - 1)) nxt = ST_IDLE;
      ST_SREQ:  if (gnt_i)   nxt = ST_SCEW;
      ST_SCEW:  if (ce_ok_i) nxt = ST_SELF;
      ST_SELF:  if (!sleep_i && (tmr >= TW'(SELF_CYC - 1))) nxt = ST_GAP;
      ST_GAP:   if (tmr == TW'(GAP_CYC - 1)) nxt = ST_CEW;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      req_q    <= 1'b0;
      strobe_q <= 1'b1;
      self_q   <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)
        tmr <= '0;
      else if (tmr != TW'(TMAX))
        tmr <= tmr + 1'b1;
      req_q    <= (nxt != ST_IDLE);
      strobe_q <= !((nxt == ST_PULSE) || (nxt == ST_SELF));
      self_q   <= (nxt == ST_SELF);
    end
  end

  assign issue_o  = (st == ST_CEW) && ce_ok_i;
  assign hold_o   = (st == ST_SELF) || (st == ST_GAP);
  assign req_o    = req_q;
  assign rfsh_n_o = strobe_q;
  assign self_o   = self_q;
endmodule

// File: rtl/psr_refresh_sched.sv
module psr_refresh_sched #(
  parameter int CLK_NS      = 10,
  parameter int INTERVAL_NS = 15000,
  parameter int DEADLINE_NS = 15600,
  parameter int PULSE_NS    = 100,
  parameter int RECOV_NS    = 100,
  parameter int CE_DLY_NS   = 50,
  parameter int SELF_MIN_NS = 9000,
  parameter int GAP_NS      = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_busy_i,
  input  logic ce_n_i,
  input  logic gnt_i,
  input  logic sleep_i,
  output logic req_o,
  output logic rfsh_n_o,
  output logic pend_o,
  output logic self_o,
  output logic err_o
);
  localparam int INT_CYC   = psr_pkg::ns2cyc(INTERVAL_NS, CLK_NS);
  localparam int DEAD_CYC  = psr_pkg::ns2cyc(DEADLINE_NS, CLK_NS);
  localparam int PULSE_CYC = psr_pkg::ns2cyc(PULSE_NS, CLK_NS);
  localparam int RECOV_CYC = psr_pkg::ns2cyc(RECOV_NS, CLK_NS);
  localparam int CE_CYC    = psr_pkg::ns2cyc(CE_DLY_NS, CLK_NS);
  localparam int SELF_CYC  = psr_pkg::ns2cyc(SELF_MIN_NS, CLK_NS);
  localparam int GAP_CYC   = psr_pkg::ns2cyc(GAP_NS, CLK_NS);

  logic ce_ok, issue, hold;

  psr_interval #(.INT_CYC(INT_CYC), .DEAD_CYC(DEAD_CYC)) i_interval (
    .clk(clk), .rst_n(rst_n), .clr_i(issue | hold),
    .pend_o(pend_o), .err_o(err_o)
  );

  psr_ce_watch #(.CE_CYC(CE_CYC)) i_ce_watch (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .ce_ok_o(ce_ok)
  );

  psr_seq_fsm #(
    .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
    .SELF_CYC(SELF_CYC), .GAP_CYC(GAP_CYC)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .busy_i(seq_busy_i),
    .gnt_i(gnt_i), .sleep_i(sleep_i), .ce_ok_i(ce_ok),
    .req_o(req_o), .rfsh_n_o(rfsh_n_o), .self_o(self_o),
    .issue_o(issue), .hold_o(hold)
  );
endmodule

// File: rtl/psr_refresh_sched_chk.sv
module psr_refresh_sched_chk #(
  parameter int PULSE_CYC = 10,
  parameter int RECOV_CYC = 10,
  parameter int CE_CYC    = 5,
  parameter int SELF_CYC  = 900
) (
  input logic clk,
  input logic rst_n,
  input logic seq_busy_i,
  input logic ce_n_i,
  input logic gnt_i,
  input logic req_o,
  input logic rfsh_n_o,
  input logic pend_o,
  input logic self_o,
  input logic err_o
);
  int low_run, hi_run, ce_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      hi_run  <= RECOV_CYC;
      ce_run  <= 0;
    end else begin
      low_run <= rfsh_n_o ? 0 : ((low_run < SELF_CYC) ? low_run + 1 : low_run);
      hi_run  <= !rfsh_n_o ? 0 : ((hi_run < RECOV_CYC) ? hi_run + 1 : hi_run);
      ce_run  <= !ce_n_i ? 0 : ((ce_run < CE_CYC) ? ce_run + 1 : ce_run);
    end
  end

  assert_req_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(seq_busy_i));
  assert_low_under_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n_o |-> req_o);
  assert_fall_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n_o) |-> $past(gnt_i));
  assert_ce_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n_o) |-> (ce_run >= CE_CYC));
  assert_pulse_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_n_o) |-> (low_run >= PULSE_CYC));
  assert_high_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n_o) |-> (hi_run >= RECOV_CYC));
  assert_err_after_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(pend_o));
  assert_self_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    self_o |-> !rfsh_n_o);
  assert_self_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_o) |-> (low_run >= SELF_CYC));
endmodule

bind psr_refresh_sched psr_refresh_sched_chk #(
  .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
  .CE_CYC(CE_CYC), .SELF_CYC(SELF_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .seq_busy_i(seq_busy_i), .ce_n_i(ce_n_i),
  .gnt_i(gnt_i), .req_o(req_o), .rfsh_n_o(rfsh_n_o), .pend_o(pend_o),
  .self_o(self_o), .err_o(err_o)
);

// File: tb/test_psr_refresh_sched.sv
module test_psr_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int INT_CYC    = 1500;
  localparam int DEAD_CYC   = 1560;
  localparam int PULSE_CYC  = 10;
  localparam int RECOV_CYC  = 10;
  localparam int CE_CYC     = 5;
  localparam int SELF_CYC   = 900;
  localparam int GAP_CYC    = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, ce_n = 1'b1, sleep = 1'b0;
  logic auto_gnt = 1'b1, gnt_man = 1'b0;
  logic gnt, req, rfsh_n, pend, slf, err;

  assign gnt = auto_gnt ? req : gnt_man;

  psr_refresh_sched #(.CLK_NS(CLK_PERIOD)) i_psr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .seq_busy_i(busy), .ce_n_i(ce_n),
    .gnt_i(gnt), .sleep_i(sleep), .req_o(req), .rfsh_n_o(rfsh_n),
    .pend_o(pend), .self_o(slf), .err_o(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, cyc_rst = 0;
  int fall_cyc = 0, rise_cyc = 0, low_w = 0, hi_w = 0, n_fall = 0, n_rise = 0;
  logic prev_s = 1'b1, req_low_seen = 1'b0;

  // Pin monitor at the falling edge; tasks sample one step later.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_s && !rfsh_n) begin
      fall_cyc = cyc; hi_w = cyc - rise_cyc; n_fall = n_fall + 1;
    end
    if (!prev_s && rfsh_n) begin
      low_w = cyc - fall_cyc; rise_cyc = cyc; n_rise = n_rise + 1;
      req_low_seen = 1'b0;
    end else if (!req) begin
      req_low_seen = 1'b1;
    end
    prev_s = rfsh_n;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; busy = 1'b0; ce_n = 1'b1; sleep = 1'b0;
    auto_gnt = 1'b1; gnt_man = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    cyc_rst = cyc;
  endtask

  task automatic wait_fall();
    int f0 = n_fall;
    while (n_fall == f0) step();
  endtask

  task automatic wait_rise();
    int r0 = n_rise;
    while (n_rise == r0) step();
  endtask

  task automatic t_reset();
    do_reset();
    chk({rfsh_n, req, pend, err, slf} == 5'b10000, "R1 reset state",
        int'({rfsh_n, req, pend, err, slf}), 16);
  endtask

  task automatic t_period();
    int f1;
    do_reset();
    while (!pend) step();
    chk(cyc - cyc_rst == INT_CYC, "R2 pending due point", cyc - cyc_rst, INT_CYC);
    wait_fall(); f1 = fall_cyc;
    wait_rise();
    chk(low_w == PULSE_CYC, "R6 pulse width", low_w, PULSE_CYC);
    chk(pend == 1'b0, "R2 pending cleared", int'(pend), 0);
    wait_fall();
    chk((fall_cyc - f1 >= INT_CYC) && (fall_cyc - f1 <= DEAD_CYC),
        "R2 pulse spacing", fall_cyc - f1, INT_CYC);
    chk(err == 1'b0, "R7 no error when on time", int'(err), 0);
  endtask

  task automatic t_busy_ce();
    int c_ce;
    do_reset();
    busy = 1'b1; ce_n = 1'b0;
    while (cyc - cyc_rst < INT_CYC + 20) step();
    chk(pend && !req && rfsh_n, "R3 no request while busy", int'(req), 0);
    busy = 1'b0; ce_n = 1'b1; c_ce = cyc;
    wait_fall();
    chk(fall_cyc - c_ce > CE_CYC, "R5 chip enable delay", fall_cyc - c_ce, CE_CYC + 1);
  endtask

  task automatic t_grant();
    int f0, c0;
    do_reset();
    auto_gnt = 1'b0;
    while (!req) step();
    chk(cyc - cyc_rst == INT_CYC + 1, "R3 request follows pending", cyc - cyc_rst, INT_CYC + 1);
    f0 = n_fall;
    repeat (30) step();
    chk(rfsh_n && (n_fall == f0), "R4 no pulse without grant", n_fall - f0, 0);
    gnt_man = 1'b1;
    wait_fall(); wait_rise();
    c0 = cyc;
    chk(req == 1'b1, "R6 request held in recovery", int'(req), 1);
    while (req) step();
    chk(cyc - c0 == RECOV_CYC, "R6 recovery length", cyc - c0, RECOV_CYC);
    gnt_man = 1'b0;
  endtask

  task automatic t_error();
    do_reset();
    busy = 1'b1;
    while (cyc - cyc_rst < DEAD_CYC - 1) step();
    chk(err == 1'b0, "R7 no error before deadline", int'(err), 0);
    step();
    chk(err == 1'b1, "R7 error at deadline", int'(err), 1);
    busy = 1'b0;
    wait_fall(); wait_rise();
    chk(err == 1'b1, "R7 error sticky", int'(err), 1);
  endtask

  task automatic t_sleep_short();
    do_reset();
    repeat (100) step();
    sleep = 1'b1;
    while (!slf) step();
    repeat (50) step();
    sleep = 1'b0;
    wait_rise();
    chk((low_w >= SELF_CYC) && (low_w <= SELF_CYC + 1), "R9 minimum self low time",
        low_w, SELF_CYC);
    chk(req && !slf, "R10 request held at exit", int'({req, slf}), 2);
    wait_fall();
    chk((hi_w >= GAP_CYC) && (hi_w < INT_CYC), "R10 reset gap then catch-up", hi_w, GAP_CYC);
    chk(req_low_seen == 1'b0, "R10 bus kept during gap", int'(req_low_seen), 0);
  endtask

  task automatic t_sleep_long();
    do_reset();
    sleep = 1'b1;
    repeat (3000) step();
    chk(slf && !rfsh_n && !pend && !err, "R8 long sleep state",
        int'({slf, rfsh_n, pend, err}), 8);
    sleep = 1'b0;
    wait_rise();
    chk(low_w >= 2990, "R8 strobe held low throughout", low_w, 2990);
  endtask

  initial begin
    t_reset();
    t_period();
    t_busy_ce();
    t_grant();
    t_error();
    t_sleep_short();
    t_sleep_long();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule